// File: doc/BRIEF.md
# DRAM Bandwidth Profiling Counters

This block watches the request side of a memory controller for a programmable number of clock cycles and gathers six statistics over that window: elapsed cycles, cycles in which the controller was busy, accepted reads, accepted writes, read bytes and write bytes. The access and byte statistics can be narrowed to one bus-master ID per run. Busy and elapsed cycles are never filtered.

When a window closes, all six counts are copied into result registers in a single cycle, and the live counters restart for the next window. A shared sequential divider then derives five values from that snapshot: the average read burst, the average write burst, the bytes per access, the data utilization percent and the bus load percent. Utilization is normalised to a bus that is 8 bytes wide and moves data on both clock edges, so it moves 16 bytes per busy cycle. A one-cycle done flag marks the moment all five values are fresh. A run repeats for a programmed number of windows, or without end.

The monitor strobes are observations of traffic that has already happened, so they carry no ready signal and can never be stalled. Every strobe that is present in a counting cycle is taken. Configuration and results are plain level signals. The configuration is sampled when a start is accepted.

Top module: `bwprof_top`

## Requirements
- R1: After reset, every result output, `res_done` and `run_active` are 0.
- R2: A `cfg_start` pulse seen while idle opens a window on the next cycle. The window lasts `cfg_window` cycles, or `DEF_WINDOW` cycles when `cfg_window` is 0. `res_total` then equals the window length, saturated.
- R3: `res_busy` counts the cycles of the window in which `mon_busy` was 1.
- R4: Read and write accesses are counted on `mon_rd_acc` and `mon_wr_acc`, and their byte counts add `mon_rd_bytes` and `mon_wr_bytes`. When `cfg_filt_en` is 1, only cycles with `mon_id` equal to `cfg_filt_id` count toward these four values.
- R5: Each counter stops at 2^CNTW-1 and does not wrap.
- R6: All six results update together on the last cycle of a window, and they hold their values at every other time.
- R7: `res_rd_burst` is read bytes / read accesses, and `res_wr_burst` is write bytes / write accesses. `res_bpa` is (read bytes + write bytes) / (read accesses + write accesses). All three are truncated, and any of them with a zero divisor is 0.
- R8: `res_util_pct` is (read bytes + write bytes) x 100 / (busy x 16), clamped to 255, and is 0 when busy is 0. `res_load_pct` is busy x 100 / total.
- R9: `res_done` pulses for exactly one cycle per window, once all five derived outputs carry that window's values.
- R10: `cfg_loops` of 0 or 1 runs one window, and N runs N windows. All-ones repeats until reset. A `cfg_start` seen during a run is ignored. `run_active` is 1 while windows are being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_busy | input | 1 | Controller active for reads or writes this cycle |
| mon_rd_acc | input | 1 | Read request accepted this cycle |
| mon_wr_acc | input | 1 | Write request accepted this cycle |
| mon_rd_bytes | input | BW | Bytes of the accepted read |
| mon_wr_bytes | input | BW | Bytes of the accepted write |
| mon_id | input | IDW | Master ID of the accepted access |
| cfg_window | input | WINW | Window length in cycles, 0 selects the default |
| cfg_filt_en | input | 1 | Enable master filtering |
| cfg_filt_id | input | IDW | Master ID profiled when filtering |
| cfg_loops | input | LW | Number of windows, all-ones for endless |
| cfg_start | input | 1 | Start pulse |
| run_active | output | 1 | Windows are being counted |
| res_total | output | CNTW | Latched elapsed cycles |
| res_busy | output | CNTW | Latched busy cycles |
| res_rd_acc | output | CNTW | Latched read accesses |
| res_wr_acc | output | CNTW | Latched write accesses |
| res_rd_bytes | output | CNTW | Latched read bytes |
| res_wr_bytes | output | CNTW | Latched write bytes |
| res_rd_burst | output | CNTW | Average read burst in bytes |
| res_wr_burst | output | CNTW | Average write burst in bytes |
| res_bpa | output | CNTW | Bytes per access |
| res_util_pct | output | 8 | Data utilization percent |
| res_load_pct | output | 8 | Bus load percent |
| res_done | output | 1 | Derived results fresh (one-cycle pulse) |

## Verification
Some properties must hold on every cycle, and the assertions check those: the done flag is a single-cycle pulse, and latched results never move while no window is open. They also check that busy cycles and each access count stay at or below elapsed cycles, and that bus load never exceeds 100. The exact values need the bench's scenarios and its cycle-level reference model. That covers the counts under random, filtered, quiet and flooding traffic, and saturation at the counter ceiling. It also covers the divide-by-zero results, the default window, a start ignored during a run, finite loop counts, and an endless run that only reset ends.

// File: rtl/bwprof_pkg.sv
package bwprof_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_st_e;
  typedef enum logic [2:0] {
    OP_RBURST, OP_WBURST, OP_BPA, OP_UTIL, OP_LOAD, OP_NONE
  } div_op_e;
  localparam int unsigned NUM_CNT = 6;
  localparam int unsigned PCT_W   = 8;
endpackage

// File: rtl/bwprof_satcnt.sv
module bwprof_satcnt #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc_en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt_q,
  output logic [W-1:0]  cnt_nxt
);
  logic [W:0] sum;

  assign sum     = {1'b0, cnt_q} + (W+1)'(inc);
  assign cnt_nxt = !inc_en ? cnt_q : (sum[W] ? {W{1'b1}} : sum[W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/bwprof_div.sv
module bwprof_div #(
  parameter int unsigned DW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [DW-1:0] quo,
  output logic          done
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, q_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [DW:0]   shf, dif;

  assign shf  = {rem_q, q_q[DW-1]};
  assign dif  = shf - {1'b0, den_q};
  assign quo  = q_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        den_q <= den;
        rem_q <= '0;
        if (den == '0) begin
          q_q    <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          q_q    <= num;
          cnt_q  <= CW'(DW);
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (!dif[DW]) begin
          rem_q <= dif[DW-1:0];
          q_q   <= {q_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= shf[DW-1:0];
          q_q   <= {q_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bwprof_calc.sv
module bwprof_calc
  import bwprof_pkg::*;
#(
  parameter int unsigned CNTW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [CNTW-1:0]  s_total,
  input  logic [CNTW-1:0]  s_busy,
  input  logic [CNTW-1:0]  s_ra,
  input  logic [CNTW-1:0]  s_wa,
  input  logic [CNTW-1:0]  s_rb,
  input  logic [CNTW-1:0]  s_wb,
  output logic [CNTW-1:0]  rd_burst,
  output logic [CNTW-1:0]  wr_burst,
  output logic [CNTW-1:0]  bpa,
  output logic [PCT_W-1:0] util_pct,
  output logic [PCT_W-1:0] load_pct,
  output logic             done
);
  localparam int unsigned DW = CNTW + 8;

  div_op_e         op_q;
  logic            issue_q, done_q;
  logic [DW-1:0]   num, den, quo, sum_b, sum_a;
  logic            div_done;
  logic [PCT_W-1:0] pct;

  assign sum_b = DW'(s_rb) + DW'(s_wb);
  assign sum_a = DW'(s_ra) + DW'(s_wa);

  always_comb begin
    num = '0;
    den = '0;
    unique case (op_q)
      OP_RBURST: begin num = DW'(s_rb);               den = DW'(s_ra); end
      OP_WBURST: begin num = DW'(s_wb);               den = DW'(s_wa); end
      OP_BPA:    begin num = sum_b;                   den = sum_a; end
      OP_UTIL:   begin num = sum_b * DW'(100);        den = DW'(s_busy) << 4; end
      OP_LOAD:   begin num = DW'(s_busy) * DW'(100);  den = DW'(s_total); end
      default:   begin num = '0;                      den = '0; end
    endcase
  end

  assign pct = (quo > DW'(255)) ? {PCT_W{1'b1}} : quo[PCT_W-1:0];

  bwprof_div #(.DW(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (issue_q),
    .num   (num),
    .den   (den),
    .quo   (quo),
    .done  (div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      issue_q  <= 1'b0;
      done_q   <= 1'b0;
      rd_burst <= '0;
      wr_burst <= '0;
      bpa      <= '0;
      util_pct <= '0;
      load_pct <= '0;
    end else begin
      done_q  <= 1'b0;
      issue_q <= 1'b0;
      if (kick) begin
        op_q    <= OP_RBURST;
        issue_q <= 1'b1;
      end else if (div_done && op_q != OP_NONE) begin
        unique case (op_q)
          OP_RBURST: begin rd_burst <= quo[CNTW-1:0]; op_q <= OP_WBURST; issue_q <= 1'b1; end
          OP_WBURST: begin wr_burst <= quo[CNTW-1:0]; op_q <= OP_BPA;    issue_q <= 1'b1; end
          OP_BPA:    begin bpa      <= quo[CNTW-1:0]; op_q <= OP_UTIL;   issue_q <= 1'b1; end
          OP_UTIL:   begin util_pct <= pct;           op_q <= OP_LOAD;   issue_q <= 1'b1; end
          OP_LOAD:   begin load_pct <= pct;           op_q <= OP_NONE;   done_q  <= 1'b1; end
          default:   op_q <= OP_NONE;
        endcase
      end
    end
  end

  assign done = done_q;
endmodule

// File: rtl/bwprof_top.sv
module bwprof_top
  import bwprof_pkg::*;
#(
  parameter int unsigned CNTW       = 32,
  parameter int unsigned BW         = 8,
  parameter int unsigned IDW        = 4,
  parameter int unsigned WINW       = 32,
  parameter int unsigned LW         = 8,
  parameter int unsigned DEF_WINDOW = 125_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_busy,
  input  logic             mon_rd_acc,
  input  logic             mon_wr_acc,
  input  logic [BW-1:0]    mon_rd_bytes,
  input  logic [BW-1:0]    mon_wr_bytes,
  input  logic [IDW-1:0]   mon_id,
  input  logic [WINW-1:0]  cfg_window,
  input  logic             cfg_filt_en,
  input  logic [IDW-1:0]   cfg_filt_id,
  input  logic [LW-1:0]    cfg_loops,
  input  logic             cfg_start,
  output logic             run_active,
  output logic [CNTW-1:0]  res_total,
  output logic [CNTW-1:0]  res_busy,
  output logic [CNTW-1:0]  res_rd_acc,
  output logic [CNTW-1:0]  res_wr_acc,
  output logic [CNTW-1:0]  res_rd_bytes,
  output logic [CNTW-1:0]  res_wr_bytes,
  output logic [CNTW-1:0]  res_rd_burst,
  output logic [CNTW-1:0]  res_wr_burst,
  output logic [CNTW-1:0]  res_bpa,
  output logic [7:0]       res_util_pct,
  output logic [7:0]       res_load_pct,
  output logic             res_done
);
  localparam int unsigned IX_TOT = 0, IX_BSY = 1, IX_RA = 2, IX_WA = 3, IX_RB = 4, IX_WB = 5;

  run_st_e         st_q;
  logic [WINW-1:0] win_q, wcnt_q;
  logic [LW-1:0]   left_q;
  logic            inf_q, fen_q, kick_q;
  logic [IDW-1:0]  fid_q;
  logic            start_acc, last, running, id_ok;

  logic [NUM_CNT-1:0] inc_en;
  logic [BW-1:0]      inc_v [NUM_CNT];
  logic [CNTW-1:0]    cq    [NUM_CNT];
  logic [CNTW-1:0]    cn    [NUM_CNT];
  logic [CNTW-1:0]    res_q [NUM_CNT];

  assign running   = (st_q == ST_RUN);
  assign start_acc = (st_q == ST_IDLE) && cfg_start;
  assign last      = running && (wcnt_q == win_q - 1'b1);
  assign id_ok     = !fen_q || (mon_id == fid_q);

  assign inc_en[IX_TOT] = running;
  assign inc_en[IX_BSY] = running && mon_busy;
  assign inc_en[IX_RA]  = running && mon_rd_acc && id_ok;
  assign inc_en[IX_WA]  = running && mon_wr_acc && id_ok;
  assign inc_en[IX_RB]  = running && mon_rd_acc && id_ok;
  assign inc_en[IX_WB]  = running && mon_wr_acc && id_ok;

  assign inc_v[IX_TOT] = BW'(1);
  assign inc_v[IX_BSY] = BW'(1);
  assign inc_v[IX_RA]  = BW'(1);
  assign inc_v[IX_WA]  = BW'(1);
  assign inc_v[IX_RB]  = mon_rd_bytes;
  assign inc_v[IX_WB]  = mon_wr_bytes;

  // Live counters and their latched copies
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    bwprof_satcnt #(.W(CNTW), .IW(BW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_acc | last),
      .inc_en  (inc_en[g]),
      .inc     (inc_v[g]),
      .cnt_q   (cq[g]),
      .cnt_nxt (cn[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    res_q[g] <= '0;
      else if (last) res_q[g] <= cn[g];
    end
  end

  // Window and loop sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      win_q  <= '0;
      wcnt_q <= '0;
      left_q <= '0;
      inf_q  <= 1'b0;
      fen_q  <= 1'b0;
      fid_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= last;
      unique case (st_q)
        ST_IDLE: if (cfg_start) begin
          st_q   <= ST_RUN;
          wcnt_q <= '0;
          win_q  <= (cfg_window == '0) ? WINW'(DEF_WINDOW) : cfg_window;
          inf_q  <= &cfg_loops;
          left_q <= (cfg_loops == '0) ? LW'(1) : cfg_loops;
          fen_q  <= cfg_filt_en;
          fid_q  <= cfg_filt_id;
        end
        ST_RUN: begin
          if (last) begin
            wcnt_q <= '0;
            if (!inf_q) begin
              left_q <= left_q - 1'b1;
              if (left_q == LW'(1)) st_q <= ST_IDLE;
            end
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  bwprof_calc #(.CNTW(CNTW)) u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick_q),
    .s_total  (res_q[IX_TOT]),
    .s_busy   (res_q[IX_BSY]),
    .s_ra     (res_q[IX_RA]),
    .s_wa     (res_q[IX_WA]),
    .s_rb     (res_q[IX_RB]),
    .s_wb     (res_q[IX_WB]),
    .rd_burst (res_rd_burst),
    .wr_burst (res_wr_burst),
    .bpa      (res_bpa),
    .util_pct (res_util_pct),
    .load_pct (res_load_pct),
    .done     (res_done)
  );

  assign run_active   = running;
  assign res_total    = res_q[IX_TOT];
  assign res_busy     = res_q[IX_BSY];
  assign res_rd_acc   = res_q[IX_RA];
  assign res_wr_acc   = res_q[IX_WA];
  assign res_rd_bytes = res_q[IX_RB];
  assign res_wr_bytes = res_q[IX_WB];
endmodule

// File: rtl/bwprof_chk.sv
module bwprof_chk #(
  parameter int unsigned CNTW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_active,
  input logic            res_done,
  input logic [CNTW-1:0] res_total,
  input logic [CNTW-1:0] res_busy,
  input logic [CNTW-1:0] res_rd_acc,
  input logic [CNTW-1:0] res_wr_acc,
  input logic [7:0]      res_load_pct
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R3
  busy_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_busy <= res_total);

  // R4
  rd_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd_acc <= res_total);

  // R4
  wr_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_acc <= res_total);

  // R8
  load_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_load_pct <= 8'd100);

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_active) |-> ($stable(res_total) && $stable(res_busy)));
endmodule

bind bwprof_top bwprof_chk #(.CNTW(CNTW)) u_bwprof_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_active   (run_active),
  .res_done     (res_done),
  .res_total    (res_total),
  .res_busy     (res_busy),
  .res_rd_acc   (res_rd_acc),
  .res_wr_acc   (res_wr_acc),
  .res_load_pct (res_load_pct)
);

// File: tb/bwprof_top_bench.sv
`timescale 1ns/1ps
module bwprof_top_bench;
  localparam int CNTW = 12, BW = 8, IDW = 4, WINW = 16, LW = 4, DEFW = 200;
  localparam longint MAXC = 4095;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic mon_busy = 0, mon_rd = 0, mon_wr = 0;
  logic [BW-1:0] mon_rb = 0, mon_wb = 0;
  logic [IDW-1:0] mon_id = 0;
  logic [WINW-1:0] cfg_window = 0;
  logic cfg_filt_en = 0;
  logic [IDW-1:0] cfg_filt_id = 0;
  logic [LW-1:0] cfg_loops = 0;
  logic cfg_start = 0;
  logic run_active, res_done;
  logic [CNTW-1:0] res_total, res_busy, res_rd_acc, res_wr_acc, res_rd_bytes, res_wr_bytes;
  logic [CNTW-1:0] res_rd_burst, res_wr_burst, res_bpa;
  logic [7:0] res_util_pct, res_load_pct;

  bwprof_top #(.CNTW(CNTW), .BW(BW), .IDW(IDW), .WINW(WINW), .LW(LW), .DEF_WINDOW(DEFW)) u_bwprof_top (
    .clk(clk), .rst_n(rst_n), .mon_busy(mon_busy), .mon_rd_acc(mon_rd), .mon_wr_acc(mon_wr),
    .mon_rd_bytes(mon_rb), .mon_wr_bytes(mon_wb), .mon_id(mon_id), .cfg_window(cfg_window),
    .cfg_filt_en(cfg_filt_en), .cfg_filt_id(cfg_filt_id), .cfg_loops(cfg_loops), .cfg_start(cfg_start),
    .run_active(run_active), .res_total(res_total), .res_busy(res_busy), .res_rd_acc(res_rd_acc),
    .res_wr_acc(res_wr_acc), .res_rd_bytes(res_rd_bytes), .res_wr_bytes(res_wr_bytes),
    .res_rd_burst(res_rd_burst), .res_wr_burst(res_wr_burst), .res_bpa(res_bpa),
    .res_util_pct(res_util_pct), .res_load_pct(res_load_pct), .res_done(res_done));

  int n_chk = 0, n_bad = 0, cyc = 0, mode = 0;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(longint v);
    return (v > MAXC) ? MAXC : v;
  endfunction
  function automatic longint dv(longint n, longint d);
    return (d == 0) ? 0 : n / d;
  endfunction

  // Reference model
  bit m_run = 0, m_inf = 0, m_fen = 0;
  int m_fid = 0, m_wc = 0, m_win = 0, m_left = 0;
  longint m_tot = 0, m_bz = 0, m_ra = 0, m_wa = 0, m_rb = 0, m_wb = 0;
  longint e_tot = 0, e_bz = 0, e_ra = 0, e_wa = 0, e_rb = 0, e_wb = 0;
  longint q_d[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_wc = 0;
      m_tot = 0; m_bz = 0; m_ra = 0; m_wa = 0; m_rb = 0; m_wb = 0;
      e_tot = 0; e_bz = 0; e_ra = 0; e_wa = 0; e_rb = 0; e_wb = 0;
      q_d.delete();
    end else if (m_run) begin
      m_tot = sat(m_tot + 1);
      if (mon_busy) m_bz = sat(m_bz + 1);
      if (!m_fen || int'(mon_id) == m_fid) begin
        if (mon_rd) begin m_ra = sat(m_ra + 1); m_rb = sat(m_rb + mon_rb); end
        if (mon_wr) begin m_wa = sat(m_wa + 1); m_wb = sat(m_wb + mon_wb); end
      end
      m_wc++;
      if (m_wc == m_win) begin
        longint u;
        e_tot = m_tot; e_bz = m_bz; e_ra = m_ra; e_wa = m_wa; e_rb = m_rb; e_wb = m_wb;
        q_d.push_back(dv(e_rb, e_ra));
        q_d.push_back(dv(e_wb, e_wa));
        q_d.push_back(dv(e_rb + e_wb, e_ra + e_wa) & MAXC);
        u = dv((e_rb + e_wb) * 100, e_bz * 16);
        q_d.push_back(u > 255 ? 255 : u);
        q_d.push_back(dv(e_bz * 100, e_tot));
        m_tot = 0; m_bz = 0; m_ra = 0; m_wa = 0; m_rb = 0; m_wb = 0;
        m_wc = 0;
        if (!m_inf) begin
          m_left--;
          if (m_left == 0) m_run = 0;
        end
      end
    end else if (cfg_start) begin
      m_run = 1; m_wc = 0;
      m_win = (cfg_window == 0) ? DEFW : int'(cfg_window);
      m_inf = (cfg_loops == 4'hF);
      m_left = (cfg_loops == 0) ? 1 : int'(cfg_loops);
      m_fen = cfg_filt_en; m_fid = int'(cfg_filt_id);
      m_tot = 0; m_bz = 0; m_ra = 0; m_wa = 0; m_rb = 0; m_wb = 0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 total", res_total, e_tot);
      chk("R3 busy", res_busy, e_bz);
      chk("R4 rd_acc", res_rd_acc, e_ra);
      chk("R4 wr_acc", res_wr_acc, e_wa);
      chk("R4 rd_bytes", res_rd_bytes, e_rb);
      chk("R4 wr_bytes", res_wr_bytes, e_wb);
      chk("R10 run_active", run_active, m_run);
      if (res_done) begin
        if (q_d.size() < 5) chk("R9 unexpected done", 1, 0);
        else begin
          chk("R7 rd_burst", res_rd_burst, q_d.pop_front());
          chk("R7 wr_burst", res_wr_burst, q_d.pop_front());
          chk("R7 bpa", res_bpa, q_d.pop_front());
          chk("R8 util", res_util_pct, q_d.pop_front());
          chk("R8 load", res_load_pct, q_d.pop_front());
        end
      end
    end
  end

  // Traffic generator, driven on the falling edge
  always @(negedge clk) begin
    case (mode)
      1: begin
        mon_busy = ($urandom % 4) != 0;
        mon_rd   = mon_busy && ($urandom % 2 == 0);
        mon_wr   = mon_busy && !mon_rd && ($urandom % 3 == 0);
        mon_rb   = BW'($urandom % 256);
        mon_wb   = BW'($urandom % 256);
        mon_id   = IDW'($urandom % 4);
      end
      2: begin
        mon_busy = 1; mon_rd = 1; mon_wr = 1; mon_rb = 8'hFF; mon_wb = 8'hFF; mon_id = 0;
      end
      default: begin
        mon_busy = 0; mon_rd = 0; mon_wr = 0; mon_rb = 0; mon_wb = 0; mon_id = 0;
      end
    endcase
  end

  task automatic kick(int win, int loops, bit fen, int fid);
    @(negedge clk);
    cfg_window = WINW'(win); cfg_loops = LW'(loops);
    cfg_filt_en = fen; cfg_filt_id = IDW'(fid);
    cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
  endtask

  task automatic wait_idle();
    while (run_active) @(negedge clk);
    repeat (140) @(negedge clk);
  endtask

  task automatic check_zero(string req);
    chk(req, run_active, 0);  chk(req, res_total, 0);   chk(req, res_busy, 0);
    chk(req, res_rd_acc, 0);  chk(req, res_wr_bytes, 0); chk(req, res_bpa, 0);
    chk(req, res_util_pct, 0); chk(req, res_load_pct, 0); chk(req, res_done, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected=finish", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check_zero("R1 reset");
    rst_n = 1;
    repeat (3) @(negedge clk);

    // random traffic, single window
    mode = 1;
    kick(150, 1, 0, 0);
    wait_idle();
    chk("R2 window length", res_total, 150);

    // filtered, three windows; results hold mid-window
    kick(160, 3, 1, 2);
    repeat (80) @(negedge clk);
    chk("R6 hold during window", res_total, 150);
    wait_idle();
    chk("R9 done per window", q_d.size(), 0);
    chk("R10 finite loops end", run_active, 0);

    // no traffic: zero divisors
    mode = 0;
    kick(150, 0, 0, 0);
    wait_idle();
    chk("R7 zero divisor", res_rd_burst, 0);
    chk("R8 util zero busy", res_util_pct, 0);
    chk("R8 load zero busy", res_load_pct, 0);

    // default window length
    mode = 1;
    kick(0, 1, 0, 0);
    wait_idle();
    chk("R2 default window", res_total, DEFW);

    // flooding traffic, saturation, start during run ignored
    mode = 2;
    kick(4200, 1, 0, 0);
    repeat (100) @(negedge clk);
    kick(150, 1, 0, 0);
    wait_idle();
    chk("R5 total sat", res_total, MAXC);
    chk("R5 rd_acc sat", res_rd_acc, MAXC);
    chk("R5 rd_bytes sat", res_rd_bytes, MAXC);
    chk("R10 start ignored", res_wr_acc, MAXC);

    // endless run, stopped by reset
    mode = 1;
    kick(150, 15, 0, 0);
    repeat (800) @(negedge clk);
    chk("R10 endless still running", run_active, 1);
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_zero("R1 reset after run");
    rst_n = 1;
    repeat (5) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule